// File: doc/BRIEF.md
# Block Word Transfer Engine

This block moves a run of 16-bit words between a local memory and an external parallel-bus device, under the control of a CPU. The CPU programs three registers over a simple write/read register bus: a first-word address, a last-word address and a control word. Setting the run bit in the control word starts the transfer. An internal word counter then walks from the first address to the last address. For each word it issues one memory access and one device access, in the order that the direction bit selects. Each access is a request held until its acknowledge arrives.

When the last word has been moved, the engine clears the run bit on its own and raises a sticky completion flag. The completion flag can drive an interrupt line. The counter only changes address bits 13:1. A transfer therefore stays inside the 16 KB window chosen by the top two bits of the first address, and it wraps within that window instead of leaving it.

Top module: `blkx_engine`

## Requirements
- R1: After reset every register reads zero, no memory or device request is raised and `irq` is low.
- R2: `reg_sel` selects the register: 0 is the first-word address, 1 is the last-word address, 2 is the control word and 3 reads zero. The address registers read back all 16 bits as written. The control word reads run in bit 0, done in bit 1, interrupt enable in bit 2 and direction in bit 3, with bits 15:4 always zero.
- R3: With direction 1, each word is a memory read (`mem_we`=0) followed by a device write (`dev_we`=1) carrying the word just read. With direction 0, each word is a device read followed by a memory write carrying the device word. Only one request is raised at a time, and each request and its address, data and write flag stay steady until its acknowledge.
- R4: `mem_addr` starts at the first-word address with bit 0 cleared and rises by 2 per word. The word at the last-word address is included, and bit 0 of both addresses is ignored, so equal word addresses move exactly one word.
- R5: Address bits 15:14 come from the first-word address throughout, and bits 13:1 wrap from 0x3FFE to 0x0000 within the window.
- R6: Writing 1 to the run bit while it is clear starts a transfer. In the cycle after the acknowledge of the final word's second access, run reads 0 and done reads 1, and no further request is raised.
- R7: Writing 0 to the done bit clears it and writing 1 leaves it unchanged. A completion in the same cycle as a clearing write leaves done set, and starting a transfer while done is set keeps it set.
- R8: `irq` equals done when interrupt enable is 1 and is held low when it is 0.
- R9: While run is set, writes to either address register and to the run and direction bits are ignored. Interrupt enable and the done clear still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 16 | Memory byte address, bit 0 zero |
| mem_wdata | output | 16 | Word written to memory |
| mem_rdata | input | 16 | Word read from memory, valid with `mem_ack` |
| mem_ack | input | 1 | Memory access done |
| dev_req | output | 1 | Device access request |
| dev_we | output | 1 | Device access is a write |
| dev_wdata | output | 16 | Word written to the device |
| dev_rdata | input | 16 | Word read from the device, valid with `dev_ack` |
| dev_ack | input | 1 | Device access done |
| irq | output | 1 | Completion interrupt |

## Verification
Two things can land on the done bit in the same cycle. The engine can set it on completion while the CPU writes the control word with the done bit clear. The bench arms an override that turns the tick carrying the final acknowledge into a control write of zero, so both reach the register at one edge. It then judges the result at the ports: done must still read 1, run 0, interrupt enable 0 and `irq` low. A write that tries to change the run and direction bits during a transfer is covered the same way. The following words must keep their original direction.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
    localparam int CTL_EN   = 0;
    localparam int CTL_DONE = 1;
    localparam int CTL_IE   = 2;
    localparam int CTL_DIR  = 3;

    localparam logic [1:0] SEL_START = 2'd0;
    localparam logic [1:0] SEL_STOP  = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_e;
endpackage

// File: rtl/blkx_regs.sv
module blkx_regs
    import blkx_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int WIN_W  = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wen,
    input  logic [1:0]              reg_sel,
    input  logic [DATA_W-1:0]       reg_wdata,
    input  logic                    finish,
    output logic [DATA_W-1:0]       reg_rdata,
    output logic [ADDR_W-WIN_W-1:0] start_top,
    output logic [WIN_W-2:0]        start_word,
    output logic [WIN_W-2:0]        stop_word,
    output logic                    run,
    output logic                    done,
    output logic                    ie,
    output logic                    dir
);
    typedef struct packed {
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] stop;
        logic              dir;
        logic              ie;
        logic              done;
        logic              en;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  wr_start, wr_stop, wr_ctrl;

    always_comb begin
        wr_start = reg_wen && (reg_sel == SEL_START);
        wr_stop  = reg_wen && (reg_sel == SEL_STOP);
        wr_ctrl  = reg_wen && (reg_sel == SEL_CTRL);
        regs_d   = regs_q;
        if (wr_start && !regs_q.en) regs_d.start = reg_wdata[ADDR_W-1:0];
        if (wr_stop && !regs_q.en)  regs_d.stop  = reg_wdata[ADDR_W-1:0];
        if (wr_ctrl) begin
            regs_d.ie = reg_wdata[CTL_IE];
            if (!reg_wdata[CTL_DONE]) regs_d.done = 1'b0;
            if (!regs_q.en) begin
                regs_d.dir = reg_wdata[CTL_DIR];
                regs_d.en  = reg_wdata[CTL_EN];
            end
        end
        // completion outranks a simultaneous CPU clear
        if (finish) begin
            regs_d.en   = 1'b0;
            regs_d.done = 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_START: reg_rdata = DATA_W'(regs_q.start);
            SEL_STOP:  reg_rdata = DATA_W'(regs_q.stop);
            SEL_CTRL: begin
                reg_rdata[CTL_EN]   = regs_q.en;
                reg_rdata[CTL_DONE] = regs_q.done;
                reg_rdata[CTL_IE]   = regs_q.ie;
                reg_rdata[CTL_DIR]  = regs_q.dir;
            end
            default: reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign start_top  = regs_q.start[ADDR_W-1:WIN_W];
    assign start_word = regs_q.start[WIN_W-1:1];
    assign stop_word  = regs_q.stop[WIN_W-1:1];
    assign run        = regs_q.en;
    assign done       = regs_q.done;
    assign ie         = regs_q.ie;
    assign dir        = regs_q.dir;

    assert_addr_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.en && $past(regs_q.en)) |-> ($stable(regs_q.start) && $stable(regs_q.stop)));

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.done && !(wr_ctrl && !reg_wdata[CTL_DONE])) |=> regs_q.done);

    assert_run_selfclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (!regs_q.en && regs_q.done));
endmodule

// File: rtl/blkx_addr_ctr.sv
module blkx_addr_ctr #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (load)      ctr_d.cnt = load_val;
        else if (step) ctr_d.cnt = ctr_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign cnt = ctr_q.cnt;
endmodule

// File: rtl/blkx_step_seq.sv
module blkx_step_seq
    import blkx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              dir,
    input  logic              last,
    input  logic              mem_ack,
    input  logic              dev_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              dev_req,
    output logic              dev_we,
    output logic [DATA_W-1:0] xfer_data,
    output logic              load,
    output logic              step,
    output logic              finish
);
    typedef struct packed {
        phase_e            phase;
        logic [DATA_W-1:0] hold;
    } seq_t;

    seq_t seq_d, seq_q;
    logic ack_first, ack_second;

    always_comb begin
        seq_d      = seq_q;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        dev_req    = 1'b0;
        dev_we     = 1'b0;
        load       = 1'b0;
        step       = 1'b0;
        finish     = 1'b0;
        ack_first  = dir ? mem_ack : dev_ack;
        ack_second = dir ? dev_ack : mem_ack;
        case (seq_q.phase)
            PH_IDLE: begin
                load = 1'b1;
                if (run) seq_d.phase = PH_FIRST;
            end
            PH_FIRST: begin
                if (dir) mem_req = 1'b1;
                else     dev_req = 1'b1;
                if (ack_first) begin
                    seq_d.hold  = dir ? mem_rdata : dev_rdata;
                    seq_d.phase = PH_SECOND;
                end
            end
            PH_SECOND: begin
                if (dir) begin
                    dev_req = 1'b1;
                    dev_we  = 1'b1;
                end else begin
                    mem_req = 1'b1;
                    mem_we  = 1'b1;
                end
                if (ack_second) begin
                    if (last) begin
                        finish      = 1'b1;
                        seq_d.phase = PH_IDLE;
                    end else begin
                        step        = 1'b1;
                        seq_d.phase = PH_FIRST;
                    end
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{phase: PH_IDLE, hold: '0};
        else        seq_q <= seq_d;
    end

    assign xfer_data = seq_q.hold;

    assert_quiet_after_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (!mem_req && !dev_req));
endmodule

// File: rtl/blkx_engine.sv
module blkx_engine #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int WIN_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              dev_req,
    output logic              dev_we,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata,
    input  logic              dev_ack,
    output logic              irq
);
    localparam int CNT_W = WIN_W - 1;
    localparam int TOP_W = ADDR_W - WIN_W;

    logic [TOP_W-1:0] start_top;
    logic [CNT_W-1:0] start_word, stop_word, cnt;
    logic             run, done, ie, dir;
    logic             load, step, finish, last;
    logic [DATA_W-1:0] xfer_data;

    blkx_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_W(WIN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .finish(finish), .reg_rdata(reg_rdata),
        .start_top(start_top), .start_word(start_word), .stop_word(stop_word),
        .run(run), .done(done), .ie(ie), .dir(dir)
    );

    blkx_addr_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(start_word),
        .step(step), .cnt(cnt)
    );

    blkx_step_seq #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .dir(dir), .last(last),
        .mem_ack(mem_ack), .dev_ack(dev_ack), .mem_rdata(mem_rdata),
        .dev_rdata(dev_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .dev_req(dev_req), .dev_we(dev_we), .xfer_data(xfer_data),
        .load(load), .step(step), .finish(finish)
    );

    assign last      = (cnt == stop_word);
    assign mem_addr  = {start_top, cnt, 1'b0};
    assign mem_wdata = xfer_data;
    assign dev_wdata = xfer_data;
    assign irq       = ie & done;

    assert_mem_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_dev_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req && !dev_ack) |=> (dev_req && $stable(dev_we) && $stable(dev_wdata)));
endmodule

// File: tb/blkx_engine_bench.sv
`timescale 1ns/1ps
module blkx_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        mem_req, mem_we, dev_req, dev_we, irq;
    logic [15:0] mem_addr, mem_wdata, dev_wdata;
    logic [15:0] mem_rdata = '0, dev_rdata = '0;
    logic        mem_ack = 1'b0, dev_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [15:0] start_m = '0, stop_m = '0, exp_addr = '0, carry = '0, dev_pat = 16'hA000;
    bit          en_m = 0, done_m = 0, ie_m = 0, dir_m = 0, ph_m = 0, clr_arm = 0;
    int          words_left = 0, lat = 1;
    logic [7:0]  lfsr = 8'h5B;
    logic [15:0] mem_m [logic [15:0]];
    string       rd_tag = "R1", addr_tag = "R4";

    always #2 clk = ~clk;

    blkx_engine u_blkx_engine (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .dev_req(dev_req),
        .dev_we(dev_we), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
        .dev_ack(dev_ack), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] model_rd(input logic [1:0] s);
        case (s)
            2'd0: return start_m;
            2'd1: return stop_m;
            2'd2: return {12'h000, dir_m, ie_m, done_m, en_m};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic int next_lat();
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        return int'(lfsr[1:0]);
    endfunction

    task automatic tick(input logic wen, input logic [1:0] sel, input logic [15:0] wd);
        bit want_mem, fin;
        @(negedge clk);
        check(reg_rdata == model_rd(reg_sel), (reg_sel == 2'd2) ? rd_tag : "R2",
              "register readback", reg_rdata, model_rd(reg_sel));
        check(irq == (done_m & ie_m), "R8", "irq", {15'd0, irq}, {15'd0, done_m & ie_m});
        mem_ack = 1'b0;
        dev_ack = 1'b0;
        fin = 0;
        if (mem_req || dev_req) begin
            want_mem = dir_m ^ ph_m;
            check(en_m, "R6", "request while no transfer runs", {15'd0, mem_req}, 16'd0);
            check(mem_req == want_mem && dev_req == !want_mem &&
                  (want_mem ? mem_we : dev_we) == ph_m, "R3", "access kind/order",
                  {12'd0, mem_req, mem_we, dev_req, dev_we},
                  {12'd0, want_mem, want_mem & ph_m, !want_mem, !want_mem & ph_m});
            if (lat == 0 && en_m) begin
                if (want_mem) begin
                    check(mem_addr == exp_addr, addr_tag, "memory address", mem_addr, exp_addr);
                    mem_ack = 1'b1;
                    if (!ph_m) begin
                        mem_rdata = mem_m.exists(exp_addr) ? mem_m[exp_addr] : 16'h0000;
                        carry = mem_rdata;
                    end else begin
                        check(mem_wdata == carry, "R3", "memory write data", mem_wdata, carry);
                        mem_m[exp_addr] = mem_wdata;
                    end
                end else begin
                    dev_ack = 1'b1;
                    if (!ph_m) begin
                        dev_pat = dev_pat + 16'h0111;
                        dev_rdata = dev_pat;
                        carry = dev_pat;
                    end else begin
                        check(dev_wdata == carry, "R3", "device write data", dev_wdata, carry);
                    end
                end
                if (ph_m) begin
                    words_left--;
                    exp_addr = {exp_addr[15:14], exp_addr[13:1] + 13'd1, 1'b0};
                    if (words_left == 0) fin = 1;
                end
                ph_m = !ph_m;
                lat = next_lat();
            end else if (lat > 0) begin
                lat--;
            end
        end
        if (fin && clr_arm) begin
            wen = 1'b1;
            sel = 2'd2;
            wd = 16'h0000;
            clr_arm = 0;
        end
        reg_wen = wen;
        reg_sel = sel;
        reg_wdata = wd;
        if (wen) begin
            case (sel)
                2'd0: if (!en_m) start_m = wd;
                2'd1: if (!en_m) stop_m = wd;
                2'd2: begin
                    ie_m = wd[2];
                    if (!wd[1]) done_m = 0;
                    if (!en_m) begin
                        dir_m = wd[3];
                        if (wd[0]) begin
                            en_m = 1;
                            ph_m = 0;
                            exp_addr = {start_m[15:1], 1'b0};
                            words_left = int'(13'(stop_m[13:1] - start_m[13:1])) + 1;
                        end
                    end
                end
                default: ;
            endcase
        end
        if (fin) begin
            en_m = 0;
            done_m = 1;
        end
    endtask

    task automatic run_to_end();
        for (int i = 0; i < 1000 && en_m; i++) tick(1'b0, 2'd2, 16'h0000);
        check(!en_m, "R6", "transfer did not complete", {15'd0, en_m}, 16'd0);
        tick(1'b0, 2'd2, 16'h0000);
        tick(1'b0, 2'd2, 16'h0000);
    endtask

    task automatic read_all();
        for (int s = 0; s < 4; s++) tick(1'b0, 2'(s), 16'h0000);
        tick(1'b0, 2'd2, 16'h0000);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(!mem_req && !dev_req && !irq, "R1", "outputs after reset",
              {13'd0, mem_req, dev_req, irq}, 16'd0);
        read_all();

        // R2: readback and reserved control bits
        rd_tag = "R2";
        tick(1'b1, 2'd0, 16'h1235);
        tick(1'b1, 2'd1, 16'h123B);
        tick(1'b1, 2'd2, 16'hFFF0);
        read_all();

        // R3/R4/R9: memory to device, four words, locked writes mid-run
        for (int i = 0; i < 4; i++) mem_m[16'h1234 + 16'(2 * i)] = 16'h5A00 + 16'(i * 7);
        rd_tag = "R6";
        tick(1'b1, 2'd2, 16'h000D);
        tick(1'b0, 2'd2, 16'h0000);
        tick(1'b0, 2'd2, 16'h0000);
        rd_tag = "R9";
        tick(1'b1, 2'd0, 16'h0100);
        tick(1'b1, 2'd1, 16'h0100);
        tick(1'b1, 2'd2, 16'h0006);
        run_to_end();
        read_all();

        // R7: writing 1 to done keeps it, writing 0 clears it
        rd_tag = "R7";
        tick(1'b1, 2'd2, 16'h0006);
        tick(1'b0, 2'd2, 16'h0000);
        tick(1'b1, 2'd2, 16'h0004);
        tick(1'b0, 2'd2, 16'h0000);

        // R4: device to memory, equal word addresses move one word, irq gated off
        tick(1'b1, 2'd0, 16'h2100);
        tick(1'b1, 2'd1, 16'h2101);
        tick(1'b1, 2'd2, 16'h0001);
        run_to_end();
        check(mem_m.exists(16'h2102) == 0, "R4", "word beyond last address written",
              16'(mem_m.exists(16'h2102)), 16'd0);

        // R7: restart while done set keeps done
        tick(1'b1, 2'd2, 16'h0003);
        run_to_end();

        // R7: completion and clearing write in the same cycle
        tick(1'b1, 2'd2, 16'h0004);
        tick(1'b1, 2'd0, 16'h0200);
        tick(1'b1, 2'd1, 16'h0206);
        for (int i = 0; i < 4; i++) mem_m[16'h0200 + 16'(2 * i)] = 16'hC300 + 16'(i);
        clr_arm = 1;
        tick(1'b1, 2'd2, 16'h000D);
        run_to_end();
        read_all();
        tick(1'b1, 2'd2, 16'h0000);

        // R5: wrap inside the 16 KB window
        addr_tag = "R5";
        rd_tag = "R5";
        tick(1'b1, 2'd0, 16'h7FFC);
        tick(1'b1, 2'd1, 16'h4002);
        mem_m[16'h7FFC] = 16'h1111;
        mem_m[16'h7FFE] = 16'h2222;
        mem_m[16'h4000] = 16'h3333;
        mem_m[16'h4002] = 16'h4444;
        tick(1'b1, 2'd2, 16'h0009);
        run_to_end();
        read_all();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule